// File: doc/BRIEF.md
# Serial segment display receiver

This block is the receiving end of a four-digit, eight-segment display that is driven over three wires: a serial data line, a serial clock and a load strobe. Each falling edge of the serial clock moves one data bit into a 32-stage shift register. While the load strobe is high, a bank of display latches copies the register and drives one output per segment. A logic 1 in a bit lights the matching segment.

The bit that leaves the last stage comes out on a data-out pin. Several receivers can therefore be chained by wiring data-out of one to data-in of the next. All of them share the clock and the load strobe. A host shifts the frame meant for the farthest receiver first. Inside a frame, the first bit ends up on the decimal point of the rightmost digit and the last bit on the G segment of the leftmost digit.

Top module: `segdisp_rx`

## Requirements
- R1: The shift register has 32 stages. After 32 falling clock edges and a load, the first bit of the frame drives the decimal point of digit 0 (the rightmost digit) and the last bit drives segment G of digit 3 (the leftmost digit).
- R2: On each falling edge of `sclk`, `sdi` is sampled into the first stage and every stage moves one place towards the last stage. Rising edges change nothing.
- R3: While `load` is 1, `seg_o` equals the current register contents under the mapping of R6 and R9.
- R4: While `load` stays at 1 across clock edges, each newly shifted bit appears on `seg_o` immediately after its falling edge.
- R5: While `load` is 0, `seg_o` keeps its last latched value whatever is shifted.
- R6: A segment is lit when its bit is 1. `seg_o[8*d+k]` drives digit d (d=0 is rightmost) and segment k, with A=0, B=1, C=2, D=3, E=4, F=5, G=6 and DP=7.
- R7: `sdo` always shows the bit held in the last stage, which is the bit that the next falling edge pushes out. A second receiver fed from `sdo` therefore holds a frame after that frame has been followed by 32 more bits.
- R8: An active-low asynchronous `rst_n` clears the shift register and the latches, so all segments go dark and `sdo` is 0.
- R9: Inside each digit, the eight bits of a frame arrive in the order DP, E, D, C, B, A, F, G.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock; the shift happens on the falling edge |
| sdi | input | 1 | Serial data in |
| load | input | 1 | Level-sensitive latch enable; latches are transparent while high |
| sdo | output | 1 | Last shift stage, used for cascading |
| seg_o | output | 32 | Segment drives, 8 per digit, 1 = lit |

## Verification
The hardest case to reach is the cascade. A bit only reaches the second receiver 32 edges after it entered the first, and both receivers latch on the same strobe. The bench chains two instances and shifts two full random frames back to back before a single load pulse. It then checks that each receiver shows the frame meant for it. The transparent mode is also hard to reach, because it needs `load` held high while the clock keeps running. The bench does this over a whole frame and compares the segments after every edge.

// File: rtl/segdisp_pkg.sv
package segdisp_pkg;
  localparam int SEG_PER_DIG = 8;

  localparam int SEG_A  = 0;
  localparam int SEG_B  = 1;
  localparam int SEG_C  = 2;
  localparam int SEG_D  = 3;
  localparam int SEG_E  = 4;
  localparam int SEG_F  = 5;
  localparam int SEG_G  = 6;
  localparam int SEG_DP = 7;

  // Segment reached by the p-th bit of a digit's group (R9 arrival order)
  function automatic int slot_seg(input int p);
    case (p)
      0:       return SEG_DP;
      1:       return SEG_E;
      2:       return SEG_D;
      3:       return SEG_C;
      4:       return SEG_B;
      5:       return SEG_A;
      6:       return SEG_F;
      default: return SEG_G;
    endcase
  endfunction

  // Stage that holds bit p of digit d once a whole frame has been shifted
  function automatic int slot_stage(input int d, input int p, input int nstage);
    return nstage - 1 - d * SEG_PER_DIG - p;
  endfunction
endpackage

// File: rtl/segdisp_shreg.sv
module segdisp_shreg #(
  parameter int N = 32
) (
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         sdi,
  output logic [N-1:0] stages
);
  logic [N-1:0] sr_q;
  logic         primed_q;

  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q     <= '0;
      primed_q <= 1'b0;
    end else begin
      sr_q     <= {sr_q[N-2:0], sdi};
      primed_q <= 1'b1;
    end
  end

  assign stages = sr_q;

  // R2
  shift_in_chk: assert property (@(negedge sclk) disable iff (!rst_n)
    primed_q |-> sr_q[0] == $past(sdi));

  // R2
  shift_along_chk: assert property (@(negedge sclk) disable iff (!rst_n)
    primed_q |-> sr_q[N-1:1] == $past(sr_q[N-2:0]));
endmodule

// File: rtl/segdisp_map.sv
module segdisp_map
  import segdisp_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int N = DIGITS * SEG_PER_DIG
) (
  input  logic [N-1:0] stages,
  output logic [N-1:0] segs
);
  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    for (genvar p = 0; p < SEG_PER_DIG; p++) begin : g_slot
      localparam int SO = d * SEG_PER_DIG + slot_seg(p);
      localparam int SI = slot_stage(d, p, N);
      assign segs[SO] = stages[SI];
    end
  end
endmodule

// File: rtl/segdisp_latch.sv
module segdisp_latch #(
  parameter int N = 32
) (
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         load,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] lat;

  always_latch begin
    if (!rst_n)    lat <= '0;
    else if (load) lat <= d;
  end

  assign q = lat;

  // Checker-only snapshot of the value held when load falls
  logic [N-1:0] snap_q;
  always_ff @(negedge load or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= lat;
  end

  // R3
  load_copy_chk: assert property (@(negedge sclk) disable iff (!rst_n)
    load |-> q == d);

  // R5
  hold_chk: assert property (@(negedge sclk) disable iff (!rst_n)
    !load |-> q == snap_q);
endmodule

// File: rtl/segdisp_rx.sv
module segdisp_rx
  import segdisp_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int N = DIGITS * SEG_PER_DIG
) (
  input  logic         rst_n,
  input  logic         sclk,
  input  logic         sdi,
  input  logic         load,
  output logic         sdo,
  output logic [N-1:0] seg_o
);
  logic [N-1:0] stages;
  logic [N-1:0] mapped;

  segdisp_shreg #(.N(N)) u_shreg (
    .rst_n (rst_n),
    .sclk  (sclk),
    .sdi   (sdi),
    .stages(stages)
  );

  segdisp_map #(.DIGITS(DIGITS)) u_map (
    .stages(stages),
    .segs  (mapped)
  );

  segdisp_latch #(.N(N)) u_latch (
    .rst_n(rst_n),
    .sclk (sclk),
    .load (load),
    .d    (mapped),
    .q    (seg_o)
  );

  assign sdo = stages[N-1];

  // Checker state: set after the first edge that follows reset
  logic primed_q;
  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= 1'b1;
  end

  // R7
  sdo_follow_chk: assert property (@(negedge sclk) disable iff (!rst_n)
    primed_q |-> sdo == $past(stages[N-2]));

  // R8
  reset_blank_chk: assert property (@(negedge sclk)
    !rst_n |-> (seg_o == '0 && sdo == 1'b0));
endmodule

// File: tb/segdisp_rx_bench.sv
module segdisp_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1;
  logic sdi = 1'b0;
  logic load = 1'b0;
  logic sdo, sdo_t;
  logic [31:0] seg, seg_t;

  int total = 0;
  int bad = 0;
  logic [31:0] m_sr = '0, m_tsr = '0, m_lat = '0, m_tlat = '0;

  always #2 clk = ~clk;

  segdisp_rx u_segdisp_rx (
    .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .load(load), .sdo(sdo), .seg_o(seg));
  segdisp_rx u_tail (
    .rst_n(rst_n), .sclk(sclk), .sdi(sdo), .load(load), .sdo(sdo_t), .seg_o(seg_t));

  // Arrival order within a digit: DP,E,D,C,B,A,F,G -> seg codes
  function automatic int code_of(input int p);
    int t[8] = '{7, 4, 3, 2, 1, 0, 5, 6};
    return t[p];
  endfunction

  // n-th bit of the stream (n=0 first) that yields target segment word
  function automatic logic bit_for(input logic [31:0] tgt, input int n);
    return tgt[8 * (n / 8) + code_of(n % 8)];
  endfunction

  // Segments shown from a register whose stage 31-n holds stream bit n
  function automatic logic [31:0] seg_from(input logic [31:0] sr);
    logic [31:0] r = '0;
    for (int n = 0; n < 32; n++) r[8 * (n / 8) + code_of(n % 8)] = sr[31 - n];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clock_bit(input logic b);
    @(negedge clk) sdi = b;
    @(posedge clk) sclk = 1'b0;
    m_tsr = {m_tsr[30:0], m_sr[31]};
    m_sr  = {m_sr[30:0], b};
    if (load) begin
      m_lat  = seg_from(m_sr);
      m_tlat = seg_from(m_tsr);
    end
    @(posedge clk) sclk = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [31:0] tgt);
    for (int n = 0; n < 32; n++) clock_bit(bit_for(tgt, n));
  endtask

  task automatic pulse_load();
    @(negedge clk) load = 1'b1;
    m_lat  = seg_from(m_sr);
    m_tlat = seg_from(m_tsr);
    @(negedge clk) load = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] fa, fb, held;
    void'($urandom(32'd1234));
    // R8 reset state, with clock activity during reset
    repeat (3) begin
      @(negedge clk) sdi = 1'b1;
      @(posedge clk) sclk = 1'b0;
      @(posedge clk) sclk = 1'b1;
    end
    @(negedge clk);
    chk(seg == '0 && seg_t == '0, "R8 reset seg", seg, 32'h0);
    chk(sdo == 1'b0, "R8 reset sdo", {31'd0, sdo}, 32'h0);
    @(negedge clk) rst_n = 1'b1;

    // R1 frame edges: first bit -> digit0 DP, last bit -> digit3 G
    fa = 32'h0000_0080;
    send_frame(fa); pulse_load();
    chk(seg == fa, "R1 first bit DP digit0", seg, fa);
    fa = 32'h4000_0000;
    send_frame(fa); pulse_load();
    chk(seg == fa, "R1 last bit G digit3", seg, fa);

    // R9 walking single bit through one digit's arrival order
    for (int p = 0; p < 8; p++) begin
      m_sr = seg == seg ? m_sr : m_sr;
      for (int n = 0; n < 32; n++) clock_bit(n == 8 + p);
      pulse_load();
      fa = 32'h1 << (8 + code_of(p));
      chk(seg == fa, "R9 digit order", seg, fa);
    end

    // R3 R6 random frames
    for (int i = 0; i < 16; i++) begin
      fa = $urandom;
      send_frame(fa); pulse_load();
      chk(seg == fa, "R3 R6 random frame", seg, fa);
    end

    // R5 hold while load low; R2 R7 sdo follows last stage
    held = seg;
    for (int i = 0; i < 13; i++) begin
      clock_bit($urandom % 2);
      chk(sdo == m_sr[31], "R2 R7 sdo", {31'd0, sdo}, {31'd0, m_sr[31]});
    end
    chk(seg == held, "R5 hold", seg, held);

    // R4 transparent with load held high
    @(negedge clk) load = 1'b1;
    m_lat = seg_from(m_sr);
    m_tlat = seg_from(m_tsr);
    @(negedge clk);
    chk(seg == m_lat, "R4 load rise", seg, m_lat);
    for (int n = 0; n < 32; n++) begin
      clock_bit($urandom % 2);
      chk(seg == seg_from(m_sr), "R4 transparent", seg, seg_from(m_sr));
    end
    @(negedge clk) load = 1'b0;

    // R7 chain: tail gets the frame pushed through the head
    fa = $urandom; fb = $urandom;
    send_frame(fa); send_frame(fb); pulse_load();
    chk(seg == fb, "R7 head frame", seg, fb);
    chk(seg_t == fa, "R7 tail frame", seg_t, fa);

    // R8 reset mid-frame
    for (int n = 0; n < 11; n++) clock_bit(1'b1);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk(seg == '0 && seg_t == '0, "R8 mid reset seg", seg, 32'h0);
    chk(sdo == 1'b0, "R8 mid reset sdo", {31'd0, sdo}, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule